// File: doc/BRIEF.md
# Right-Justified Stereo Serial Audio Transmitter

This block turns parallel stereo sample pairs into the three-wire serial stream expected by a two-channel audio DAC that uses the LSB-aligned (right-justified) format. From a single system clock it derives a bit clock, a word-select clock and a serial data line. Each 16-bit two's-complement word is shifted out most significant bit first. Its final bit falls in the last bit-clock period before word select changes level. Serial data and word select change only on falling bit-clock edges, so the receiver can capture them on rising edges.

Samples arrive through a valid/ready handshake into a one-pair holding register. The transmit state machine has three states: `IDLE`, `SEND_R` (word select low, right channel) and `SEND_L` (word select high, left channel). It has three transitions, all taken on a falling-edge tick. START goes from `IDLE` to `SEND_R` once a pair is waiting. SWAP goes from `SEND_R` to `SEND_L` after the last bit of the right half. NEXT_FRAME goes from `SEND_L` to `SEND_R` after the last bit of the left half. On NEXT_FRAME a waiting pair is taken, or the current pair is sent again if none is waiting. When a half-frame is longer than 16 bit periods, its leading periods carry zero padding.

Top module: `rj_audio_tx`

## Requirements
- R1: While and just after reset, `bclk`, `wsel` and `sdout` are low and `pair_ready` is high.
- R2: `bclk` is a square wave whose period is 2*CLK_DIV system clocks.
- R3: `sdout` and `wsel` change only in the system-clock cycle in which `bclk` falls.
- R4: A frame is a half with `wsel` low followed by a half with `wsel` high, each exactly HALF_BITS bit-clock periods long.
- R5: The half with `wsel` low carries `pair_right` and the half with `wsel` high carries `pair_left`. Each word is sent MSB first as its raw 16-bit two's-complement value, and its LSB occupies the last bit period of the half.
- R6: The first HALF_BITS-16 bit periods of each half carry zero.
- R7: `pair_ready` is high exactly when the holding register is empty. A pair is accepted when `pair_valid` and `pair_ready` are both high, and `pair_ready` then stays low until that pair is taken for transmission.
- R8: A held pair is taken only at a frame start (START or NEXT_FRAME). A pair accepted mid-frame does not change the frame in progress.
- R9: If no new pair is held at a frame start, the previous pair is sent again.
- R10: Until the first pair is taken, `wsel` and `sdout` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pair_valid | input | 1 | A stereo pair is offered |
| pair_ready | output | 1 | Holding register is free |
| pair_left | input | 16 | Left-channel sample, two's complement |
| pair_right | input | 16 | Right-channel sample, two's complement |
| bclk | output | 1 | Serial bit clock |
| wsel | output | 1 | Word select: low = right, high = left |
| sdout | output | 1 | Serial data, MSB first, right-justified |

## Verification
Random sample pairs are offered after random idle gaps. Short gaps present a new pair mid-frame, which separates correct boundary-only loading from early loading. Long gaps span several frames, which exposes any failure to repeat the last pair. Directed extreme words (0x8000, 0x7FFF, 0xFFFF, 0x0001) distinguish MSB-first from LSB-first order, show whether the word is aligned to the end of the half, and show whether the padding is zero. A half-frame length longer than 16 makes that padding visible. Every half is decoded from the pins alone and compared with the pair the bench knows was taken.

// File: rtl/rjtx_pkg.sv
package rjtx_pkg;
    typedef enum logic [1:0] {
        IDLE   = 2'd0,
        SEND_R = 2'd1,
        SEND_L = 2'd2
    } tx_state_t;
endpackage

// File: rtl/rjtx_clkgen.sv
module rjtx_clkgen #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk,
    output logic fall_tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          bclk_q;
    logic          wrap;

    assign wrap      = (cnt_q == LAST);
    assign fall_tick = wrap & bclk_q;
    assign bclk      = bclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
        end else begin
            cnt_q <= wrap ? '0 : cnt_q + CW'(1);
            if (wrap) bclk_q <= ~bclk_q;
        end
    end

    // R2: bit clock toggles only after a full divider count
    a_r2_bclk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bclk_q) |-> $past(cnt_q) == LAST);
endmodule

// File: rtl/rjtx_frame.sv
module rjtx_frame
    import rjtx_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int HALF_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_tick,
    input  logic              pair_valid,
    output logic              pair_ready,
    input  logic [WORD_W-1:0] pair_left,
    input  logic [WORD_W-1:0] pair_right,
    output logic              wsel,
    output logic              sdout
);
    localparam int BW  = (HALF_BITS > 1) ? $clog2(HALF_BITS) : 1;
    localparam int PAD = HALF_BITS - WORD_W;
    localparam logic [BW-1:0] LAST_BIT = BW'(HALF_BITS - 1);

    tx_state_t         state_q, state_d;
    logic [BW-1:0]     bit_q, bit_d;
    logic [WORD_W-1:0] act_l, act_r, hold_l, hold_r;
    logic [WORD_W-1:0] nxt_l, nxt_r, word_d;
    logic              hold_full, take;
    logic              ws_q, sd_q;

    function automatic logic pick_bit(input logic [WORD_W-1:0] w, input logic [BW-1:0] pos);
        int p;
        p = int'(pos);
        if (p < PAD) return 1'b0;
        return w[WORD_W-1-(p-PAD)];
    endfunction

    // next-state logic
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        take    = 1'b0;
        if (fall_tick) begin
            unique case (state_q)
                IDLE: begin
                    if (hold_full) begin
                        state_d = SEND_R;
                        bit_d   = '0;
                        take    = 1'b1;
                    end
                end
                SEND_R: begin
                    if (bit_q == LAST_BIT) begin
                        state_d = SEND_L;
                        bit_d   = '0;
                    end else begin
                        bit_d = bit_q + BW'(1);
                    end
                end
                SEND_L: begin
                    if (bit_q == LAST_BIT) begin
                        state_d = SEND_R;
                        bit_d   = '0;
                        take    = hold_full;
                    end else begin
                        bit_d = bit_q + BW'(1);
                    end
                end
                default: state_d = IDLE;
            endcase
        end
    end

    assign nxt_l  = take ? hold_l : act_l;
    assign nxt_r  = take ? hold_r : act_r;
    assign word_d = (state_d == SEND_L) ? nxt_l : nxt_r;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IDLE;
            bit_q   <= '0;
            act_l   <= '0;
            act_r   <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            if (take) begin
                act_l <= hold_l;
                act_r <= hold_r;
            end
        end
    end

    // holding register and handshake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_l    <= '0;
            hold_r    <= '0;
        end else if (pair_valid && !hold_full) begin
            hold_full <= 1'b1;
            hold_l    <= pair_left;
            hold_r    <= pair_right;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

    assign pair_ready = ~hold_full;

    // serial outputs, updated on the falling-edge tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_q <= 1'b0;
            sd_q <= 1'b0;
        end else if (fall_tick && state_d != IDLE) begin
            ws_q <= (state_d == SEND_L);
            sd_q <= pick_bit(word_d, bit_d);
        end
    end

    assign wsel  = ws_q;
    assign sdout = sd_q;

    // R4: word select changes only after the last bit of a half
    a_r4_ws_at_half_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws_q) |-> ($past(bit_q) == LAST_BIT && $past(state_q) != IDLE));
    // R7: an accepted pair blocks further acceptance on the next cycle
    a_r7_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && pair_ready) |=> !pair_ready);
    // R8: the active pair changes only at a frame start
    a_r8_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_l) |-> ($past(fall_tick) && $past(state_q) != SEND_R && $past(bit_q) == LAST_BIT
                             || $past(state_q) == IDLE));
    // R10: nothing leaves the pins before the first pair
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IDLE) |-> (!ws_q && !sd_q));
endmodule

// File: rtl/rj_audio_tx.sv
module rj_audio_tx #(
    parameter int WORD_W    = 16,
    parameter int HALF_BITS = 16,
    parameter int CLK_DIV   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_valid,
    output logic              pair_ready,
    input  logic [WORD_W-1:0] pair_left,
    input  logic [WORD_W-1:0] pair_right,
    output logic              bclk,
    output logic              wsel,
    output logic              sdout
);
    logic fall_tick;

    rjtx_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk      (bclk),
        .fall_tick (fall_tick)
    );

    rjtx_frame #(.WORD_W(WORD_W), .HALF_BITS(HALF_BITS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_tick  (fall_tick),
        .pair_valid (pair_valid),
        .pair_ready (pair_ready),
        .pair_left  (pair_left),
        .pair_right (pair_right),
        .wsel       (wsel),
        .sdout      (sdout)
    );

    // R3: serial data moves only as the bit clock falls
    a_r3_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdout) |-> $fell(bclk));
    // R3: word select moves only as the bit clock falls
    a_r3_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wsel) |-> $fell(bclk));
endmodule

// File: tb/test_rj_audio_tx.sv
module test_rj_audio_tx;
    localparam int W  = 16;
    localparam int HB = 18;
    localparam int CD = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pair_valid = 1'b0;
    logic [W-1:0] pair_left = '0, pair_right = '0;
    logic         pair_ready, bclk, wsel, sdout;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    bit started = 1'b0;
    logic [W-1:0] cur_l = '0, cur_r = '0, lat_l = '0, lat_r = '0;
    int idle_bad = 0, edge_bad = 0;

    always #10 clk = ~clk;

    rj_audio_tx #(.WORD_W(W), .HALF_BITS(HB), .CLK_DIV(CD)) i_rj_audio_tx (
        .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .pair_ready(pair_ready),
        .pair_left(pair_left), .pair_right(pair_right),
        .bclk(bclk), .wsel(wsel), .sdout(sdout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [HB-1:0] expect_half(input logic [W-1:0] w);
        return {{(HB-W){1'b0}}, w};
    endfunction

    // pin-level decoder, sampled just after each rising bit-clock edge
    logic [HB-1:0] col = '0;
    int  nbits = 0;
    logic half_ws = 1'b0;
    realtime last_rise = 0;
    int  per_checks = 0;
    always begin
        @(posedge bclk);
        #1;
        if (last_rise != 0 && per_checks < 8) begin
            per_checks++;
            check(($realtime - last_rise) == 2.0 * CD * 20.0, "R2 bclk period",
                  int'($realtime - last_rise), 2 * CD * 20);
        end
        last_rise = $realtime;
        if (started && !done) begin
            if (nbits > 0 && wsel != half_ws) begin
                check(nbits == HB, "R4 half length", nbits, HB);
                check(col[HB-1:W] == '0, "R6 padding", int'(col[HB-1:W]), 0);
                if (!half_ws)
                    check(col == expect_half(lat_r), "R5/R8/R9 right word", int'(col), int'(expect_half(lat_r)));
                else
                    check(col == expect_half(lat_l), "R5/R8/R9 left word", int'(col), int'(expect_half(lat_l)));
                nbits = 0;
            end
            if (nbits == 0) begin
                half_ws = wsel;
                if (!wsel) begin
                    lat_l = cur_l;
                    lat_r = cur_r;
                end
            end
            col = {col[HB-2:0], sdout};
            nbits++;
        end
    end

    // R3 and R10 observers at the falling system-clock edge
    logic pb = 1'b0, psd = 1'b0, pws = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if ((sdout != psd || wsel != pws) && !(pb && !bclk)) edge_bad++;
            if (!started && (wsel || sdout)) idle_bad++;
        end
        pb = bclk; psd = sdout; pws = wsel;
    end

    task automatic send(input logic [W-1:0] l, input logic [W-1:0] r);
        while (!pair_ready) @(negedge clk);
        pair_valid = 1'b1; pair_left = l; pair_right = r;
        @(negedge clk);
        pair_valid = 1'b0;
        check(pair_ready == 1'b0, "R7 ready low after accept", pair_ready, 0);
        while (!pair_ready) @(negedge clk);
        cur_l = l; cur_r = r;
        started = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(bclk == 0 && wsel == 0 && sdout == 0, "R1 outputs low in reset", {bclk, wsel, sdout}, 0);
        check(pair_ready == 1, "R1 ready in reset", pair_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(wsel == 0 && sdout == 0 && pair_ready == 1, "R1 after reset", {wsel, sdout, pair_ready}, 1);
        repeat (300) @(negedge clk);
        check(idle_bad == 0, "R10 idle pins quiet", idle_bad, 0);

        // directed extremes
        send(16'h8000, 16'h7FFF);
        send(16'hFFFF, 16'h0001);
        // mid-frame offer: the current frame must be unaffected (R8)
        repeat (30) @(negedge clk);
        send(16'hA5C3, 16'h3C5A);
        // long gap: the pair must repeat (R9)
        repeat (5 * 2 * HB * 2 * CD) @(negedge clk);
        for (int i = 0; i < 25; i++) begin
            logic [W-1:0] l, r;
            int gap;
            l = W'($urandom);
            r = W'($urandom);
            gap = $urandom_range(0, 400);
            repeat (gap) @(negedge clk);
            send(l, r);
        end
        repeat (3 * 2 * HB * 2 * CD) @(negedge clk);
        check(edge_bad == 0, "R3 changes only on bclk fall", edge_bad, 0);
        finish_run();
    end
endmodule